// File: doc/BRIEF.md
# Double-Buffered Loop Coefficient Bank

This block is the configuration store for one loop filter. It keeps two sets of six 6-bit bandwidth coefficients: one for normal tracking and one for fast acquisition. Each coefficient has two copies. Host writes land in a staging copy. An active copy drives the filter. The active copies change only when software issues a commit or a device-wide soft reset occurs. So the filter sees either the full old set or the full new set, and never a mix of the two.

The host reaches the bank over a simple synchronous register bus. A write takes effect at the clock edge where the write enable is sampled. Read data is combinational from the address, so it is valid in the same cycle. The bank also passes through a read-only 2-bit field that reports which of four input clocks is in use. It accepts two soft-reset requests, one device-wide and one for this loop alone, either as input pulses or as bus writes. A loop-only reset leaves the active coefficients untouched. Its only effect is a one-cycle flush pulse sent towards the filter.

Top module: `lpb_loop_param_bank`

## Requirements
- R1: Normal-tracking coefficient k (k = 0..5) is read/write at byte address 0x0608+k in bits 5:0, and a write appears on reads from the next cycle.
- R2: Fast-acquisition coefficient k (k = 0..5) is read/write at byte address 0x060E+k in bits 5:0.
- R3: A write with bit 0 set at address 0x0614 copies all twelve staging values into the active outputs at that one clock edge, so they are visible on `act_norm_o`/`act_fast_o` (coefficient k in bits 6k+5:6k) in the next cycle.
- R4: A write with bit 0 clear at 0x0614 changes nothing, and address 0x0614 always reads as zero, because the commit bit clears itself.
- R5: A device-wide soft reset, given as a one-cycle `dev_srst_i` pulse or as a write with bit 0 set at address 0x001C, commits the staging values exactly as R3 does. The commit uses the staging values from before any write in the same cycle.
- R6: A loop-only soft reset, given as `loop_srst_i` or as a write with bit 3 set at 0x001C, leaves the active values unchanged and raises `loop_flush_o` for exactly the following cycle. Address 0x001C reads as zero.
- R7: Address 0x0607 reads the selected input `in_sel_i` (0..3) in bits 7:6. Writes to 0x0607 are ignored.
- R8: Bits 7:6 of every coefficient address and bits 5:0 of 0x0607 read as zero, and written values in those bits are dropped.
- R9: Reads of coefficient addresses return the staging value, even when it differs from the active value.
- R10: After hardware reset, both copies of normal coefficient k hold 8+k and both copies of fast coefficient k hold 20+k.
- R11: Any address not listed above reads as zero, and a write to it changes no state.
- R12: Active values change only at an edge where a commit (R3 or R5) is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 16 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write enable, sampled at the rising edge |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| in_sel_i | input | 2 | Selected input clock index from the selection logic |
| dev_srst_i | input | 1 | Device-wide soft reset pulse |
| loop_srst_i | input | 1 | Loop-only soft reset pulse |
| act_norm_o | output | 36 | Active normal-tracking coefficients, 6 bits each |
| act_fast_o | output | 36 | Active fast-acquisition coefficients, 6 bits each |
| loop_flush_o | output | 1 | One-cycle pulse after a loop-only soft reset |

## Verification
A staging write or a commit is sampled at one rising edge. Both are visible at the next falling edge: the staging value on the read port and the copy on the active outputs. The flush pulse is also high at that falling edge and low one cycle later. Read data has no register stage, so the bench drives the address at a falling edge and samples one nanosecond later. Each stimulus step is one full cycle from a falling edge to the next. After every step the bench compares all twelve active fields, one read and the flush output with its model before the next step is driven.

// File: rtl/lpb_pkg.sv
`timescale 1ns/1ps
package lpb_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 2;

  // Fixed map anchors; coefficient and commit addresses are derived from these.
  localparam logic [ADDR_W-1:0] A_SRST   = 16'h001C;
  localparam logic [ADDR_W-1:0] A_STATUS = 16'h0607;
  localparam logic [ADDR_W-1:0] A_NORM0  = 16'h0608;

  localparam int unsigned SRST_DEV_BIT  = 0;
  localparam int unsigned SRST_LOOP_BIT = 3;
  localparam int unsigned COMMIT_BIT    = 0;

  function automatic logic [ADDR_W-1:0] fast_base(input int unsigned n);
    return A_NORM0 + ADDR_W'(n);
  endfunction

  function automatic logic [ADDR_W-1:0] commit_addr(input int unsigned n);
    return A_NORM0 + ADDR_W'(2 * n);
  endfunction
endpackage

// File: rtl/lpb_rst_sync.sv
`timescale 1ns/1ps
module lpb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lpb_decode.sv
`timescale 1ns/1ps
module lpb_decode
  import lpb_pkg::*;
#(
  parameter int unsigned NUM_COEF = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                we,
  input  logic                dev_srst,
  input  logic                loop_srst,
  output logic [NUM_COEF-1:0] norm_hit,
  output logic [NUM_COEF-1:0] fast_hit,
  output logic [NUM_COEF-1:0] norm_we,
  output logic [NUM_COEF-1:0] fast_we,
  output logic                status_hit,
  output logic                commit,
  output logic                loop_req
);
  localparam logic [ADDR_W-1:0] A_FAST0  = fast_base(NUM_COEF);
  localparam logic [ADDR_W-1:0] A_COMMIT = commit_addr(NUM_COEF);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar g = 0; g < NUM_COEF; g++) begin : g_hit
    assign norm_hit[g] = (addr == A_NORM0 + ADDR_W'(g));
    assign fast_hit[g] = (addr == A_FAST0 + ADDR_W'(g));
  end

  logic commit_wr;
  logic srst_wr;

  always_comb begin
    status_hit = (addr == A_STATUS);
    commit_wr  = we && (addr == A_COMMIT) && wdata[COMMIT_BIT];
    srst_wr    = we && (addr == A_SRST);
    norm_we    = we ? norm_hit : '0;
    fast_we    = we ? fast_hit : '0;
    commit     = dev_srst || commit_wr || (srst_wr && wdata[SRST_DEV_BIT]);
    loop_req   = loop_srst || (srst_wr && wdata[SRST_LOOP_BIT]);
  end
endmodule

// File: rtl/lpb_coef_slot.sv
`timescale 1ns/1ps
module lpb_coef_slot #(
  parameter int unsigned       COEF_W  = 6,
  parameter logic [COEF_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_we,
  input  logic [COEF_W-1:0] stg_d,
  input  logic              commit,
  output logic [COEF_W-1:0] stg_q,
  output logic [COEF_W-1:0] act_q
);
  logic [COEF_W-1:0] stg_nxt;
  logic [COEF_W-1:0] act_nxt;

  always_comb begin
    stg_nxt = stg_we ? stg_d : stg_q;
    act_nxt = commit ? stg_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= RST_VAL;
      act_q <= RST_VAL;
    end else begin
      stg_q <= stg_nxt;
      act_q <= act_nxt;
    end
  end
endmodule

// File: rtl/lpb_loop_param_bank.sv
`timescale 1ns/1ps
module lpb_loop_param_bank
  import lpb_pkg::*;
#(
  parameter int unsigned NUM_COEF      = 6,
  parameter int unsigned COEF_W        = 6,
  parameter int unsigned NORM_DEF_BASE = 8,
  parameter int unsigned FAST_DEF_BASE = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic [DATA_W-1:0]            bus_wdata_i,
  input  logic                         bus_we_i,
  output logic [DATA_W-1:0]            bus_rdata_o,
  input  logic [SEL_W-1:0]             in_sel_i,
  input  logic                         dev_srst_i,
  input  logic                         loop_srst_i,
  output logic [NUM_COEF*COEF_W-1:0]   act_norm_o,
  output logic [NUM_COEF*COEF_W-1:0]   act_fast_o,
  output logic                         loop_flush_o
);
  localparam int unsigned FLAT_W = NUM_COEF * COEF_W;

  logic                rst_sync_n;
  logic [NUM_COEF-1:0] norm_hit, fast_hit, norm_we, fast_we;
  logic                status_hit, commit, loop_req;
  logic [FLAT_W-1:0]   stg_norm_flat, stg_fast_flat;
  logic                flush_nxt, flush_q;

  lpb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpb_decode #(.NUM_COEF(NUM_COEF)) i_decode (
    .addr       (bus_addr_i),
    .wdata      (bus_wdata_i),
    .we         (bus_we_i),
    .dev_srst   (dev_srst_i),
    .loop_srst  (loop_srst_i),
    .norm_hit   (norm_hit),
    .fast_hit   (fast_hit),
    .norm_we    (norm_we),
    .fast_we    (fast_we),
    .status_hit (status_hit),
    .commit     (commit),
    .loop_req   (loop_req)
  );

  for (genvar g = 0; g < NUM_COEF; g++) begin : g_slot
    lpb_coef_slot #(
      .COEF_W  (COEF_W),
      .RST_VAL (COEF_W'(NORM_DEF_BASE + g))
    ) i_norm (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .stg_we (norm_we[g]),
      .stg_d  (bus_wdata_i[COEF_W-1:0]),
      .commit (commit),
      .stg_q  (stg_norm_flat[g*COEF_W +: COEF_W]),
      .act_q  (act_norm_o[g*COEF_W +: COEF_W])
    );
    lpb_coef_slot #(
      .COEF_W  (COEF_W),
      .RST_VAL (COEF_W'(FAST_DEF_BASE + g))
    ) i_fast (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .stg_we (fast_we[g]),
      .stg_d  (bus_wdata_i[COEF_W-1:0]),
      .commit (commit),
      .stg_q  (stg_fast_flat[g*COEF_W +: COEF_W]),
      .act_q  (act_fast_o[g*COEF_W +: COEF_W])
    );
  end

  // Read path: staging values, status field, zero elsewhere.
  always_comb begin
    bus_rdata_o = '0;
    if (status_hit) bus_rdata_o[DATA_W-1 -: SEL_W] = in_sel_i;
    for (int k = 0; k < NUM_COEF; k++) begin
      if (norm_hit[k]) bus_rdata_o[COEF_W-1:0] = stg_norm_flat[k*COEF_W +: COEF_W];
      if (fast_hit[k]) bus_rdata_o[COEF_W-1:0] = stg_fast_flat[k*COEF_W +: COEF_W];
    end
  end

  always_comb begin
    flush_nxt = loop_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flush_q <= 1'b0;
    else             flush_q <= flush_nxt;
  end

  assign loop_flush_o = flush_q;
endmodule

// File: rtl/lpb_loop_param_bank_chk.sv
`timescale 1ns/1ps
module lpb_loop_param_bank_chk
  import lpb_pkg::*;
#(
  parameter int unsigned NUM_COEF = 6,
  parameter int unsigned COEF_W   = 6
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic [ADDR_W-1:0]          bus_addr_i,
  input logic [DATA_W-1:0]          bus_wdata_i,
  input logic                       bus_we_i,
  input logic [DATA_W-1:0]          bus_rdata_o,
  input logic [SEL_W-1:0]           in_sel_i,
  input logic                       dev_srst_i,
  input logic                       loop_srst_i,
  input logic [NUM_COEF*COEF_W-1:0] act_norm_o,
  input logic [NUM_COEF*COEF_W-1:0] act_fast_o,
  input logic [NUM_COEF*COEF_W-1:0] stg_norm_flat,
  input logic [NUM_COEF*COEF_W-1:0] stg_fast_flat,
  input logic                       loop_flush_o
);
  localparam logic [ADDR_W-1:0] C_COMMIT = commit_addr(NUM_COEF);

  logic commit_ev, loop_ev;
  assign commit_ev = dev_srst_i
                  || (bus_we_i && bus_addr_i == C_COMMIT && bus_wdata_i[0])
                  || (bus_we_i && bus_addr_i == A_SRST && bus_wdata_i[0]);
  assign loop_ev   = loop_srst_i || (bus_we_i && bus_addr_i == A_SRST && bus_wdata_i[3]);

  a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_sync_n)
    commit_ev |=> (act_norm_o == $past(stg_norm_flat)) && (act_fast_o == $past(stg_fast_flat)));

  a_r12_active_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !commit_ev |=> $stable(act_norm_o) && $stable(act_fast_o));

  a_r6_flush_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    loop_ev |=> loop_flush_o);

  a_r6_no_stray_flush: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !loop_ev |=> !loop_flush_o);

  a_r7_status_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr_i == A_STATUS) |-> (bus_rdata_o == {in_sel_i, {(DATA_W-SEL_W){1'b0}}}));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr_i != A_STATUS) |-> (bus_rdata_o[DATA_W-1:COEF_W] == '0));

  a_r4_commit_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr_i == C_COMMIT || bus_addr_i == A_SRST) |-> (bus_rdata_o == '0));
endmodule

bind lpb_loop_param_bank lpb_loop_param_bank_chk #(
  .NUM_COEF (NUM_COEF),
  .COEF_W   (COEF_W)
) i_chk (.*);

// File: tb/test_lpb_loop_param_bank.sv
`timescale 1ns/1ps
module test_lpb_loop_param_bank;
  localparam int NC = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr_i;
  logic [7:0]  bus_wdata_i;
  logic        bus_we_i;
  logic [7:0]  bus_rdata_o;
  logic [1:0]  in_sel_i;
  logic        dev_srst_i, loop_srst_i;
  logic [35:0] act_norm_o, act_fast_o;
  logic        loop_flush_o;

  int checks = 0;
  int errors = 0;

  logic [5:0] m_sn[NC], m_sf[NC], m_an[NC], m_af[NC];
  logic       m_flush;

  always #4 clk = ~clk;

  lpb_loop_param_bank i_lpb_loop_param_bank (.*);

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (a == 16'h0607) return {in_sel_i, 6'd0};
    if (a >= 16'h0608 && a < 16'h060E) return {2'b00, m_sn[a - 16'h0608]};
    if (a >= 16'h060E && a < 16'h0614) return {2'b00, m_sf[a - 16'h060E]};
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_active(input string req);
    for (int k = 0; k < NC; k++) begin
      check(req, 64'(act_norm_o[k*6 +: 6]), 64'(m_an[k]));
      check(req, 64'(act_fast_o[k*6 +: 6]), 64'(m_af[k]));
    end
  endtask

  task automatic read_check(input logic [15:0] a, input string req);
    bus_addr_i = a;
    bus_we_i   = 1'b0;
    #1;
    check(req, 64'(bus_rdata_o), 64'(exp_read(a)));
  endtask

  // One cycle from a falling edge to the next, model updated at the rising edge.
  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic we,
                      input logic dev, input logic lp);
    logic com;
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = we;
    dev_srst_i = dev; loop_srst_i = lp;
    @(posedge clk);
    com = dev || (we && a == 16'h0614 && d[0]) || (we && a == 16'h001C && d[0]);
    m_flush = lp || (we && a == 16'h001C && d[3]);
    if (com) for (int k = 0; k < NC; k++) begin m_an[k] = m_sn[k]; m_af[k] = m_sf[k]; end
    if (we && a >= 16'h0608 && a < 16'h060E) m_sn[a - 16'h0608] = d[5:0];
    if (we && a >= 16'h060E && a < 16'h0614) m_sf[a - 16'h060E] = d[5:0];
    @(negedge clk);
    bus_we_i = 1'b0; dev_srst_i = 1'b0; loop_srst_i = 1'b0;
    check("R6 flush", 64'(loop_flush_o), 64'(m_flush));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_addr_i = '0; bus_wdata_i = '0; bus_we_i = 1'b0;
    in_sel_i = 2'd2; dev_srst_i = 1'b0; loop_srst_i = 1'b0;
    for (int k = 0; k < NC; k++) begin
      m_sn[k] = 6'(8 + k); m_an[k] = 6'(8 + k);
      m_sf[k] = 6'(20 + k); m_af[k] = 6'(20 + k);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset defaults, on outputs and on reads
    check_active("R10 reset active");
    for (int k = 0; k < 12; k++) read_check(16'(16'h0608 + k), "R10 reset staging");
    check("R6 flush idle after reset", 64'(loop_flush_o), 64'd0);

    // R1/R2/R8/R9: staging write is readable, upper bits dropped, active untouched
    step(16'h0608, 8'hFF, 1'b1, 1'b0, 1'b0);
    read_check(16'h0608, "R1 R8 normal write");
    step(16'h0613, 8'hC5, 1'b1, 1'b0, 1'b0);
    read_check(16'h0613, "R2 R8 fast write");
    check_active("R9 R12 active unchanged before commit");
    check("R9 read returns staging", 64'(bus_rdata_o), 64'h05);

    // R4: commit with bit 0 clear has no effect, commit address reads zero
    step(16'h0614, 8'hFE, 1'b1, 1'b0, 1'b0);
    check_active("R4 zero commit ignored");
    read_check(16'h0614, "R4 commit reads zero");

    // R3: commit copies all twelve
    step(16'h0614, 8'h01, 1'b1, 1'b0, 1'b0);
    check_active("R3 commit");
    read_check(16'h0614, "R4 commit self-cleared");

    // R6: loop reset by bus and by input does not commit
    step(16'h0609, 8'h2A, 1'b1, 1'b0, 1'b0);
    step(16'h001C, 8'h08, 1'b1, 1'b0, 1'b0);
    check_active("R6 bus loop reset no commit");
    step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b1);
    check_active("R6 input loop reset no commit");
    read_check(16'h001C, "R6 soft reset address reads zero");

    // R5: device reset via bus, and via input coinciding with a staging write
    step(16'h001C, 8'h01, 1'b1, 1'b0, 1'b0);
    check_active("R5 bus device reset commit");
    step(16'h060A, 8'h11, 1'b1, 1'b1, 1'b0);
    check_active("R5 device reset uses old staging");
    read_check(16'h060A, "R5 staging write in same cycle");

    // R7: status field, writes ignored
    for (int s = 0; s < 4; s++) begin
      in_sel_i = 2'(s);
      step(16'h0607, 8'hFF, 1'b1, 1'b0, 1'b0);
      read_check(16'h0607, "R7 status read");
    end

    // R11: undecoded addresses read zero and writes change nothing
    step(16'h0615, 8'h3F, 1'b1, 1'b0, 1'b0);
    read_check(16'h0615, "R11 undecoded read");
    step(16'h0606, 8'h3F, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) read_check(16'(16'h0608 + k), "R11 staging intact");
    check_active("R11 active intact");

    // Random mix, checked against the model after every step
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 8)
        0, 1, 2, 3: a = 16'(16'h0608 + ($urandom % 12));
        4:          a = 16'h0614;
        5:          a = 16'h001C;
        6:          a = 16'h0607;
        default:    a = 16'($urandom);
      endcase
      d = 8'($urandom);
      in_sel_i = 2'($urandom);
      step(a, d, ($urandom % 8) != 0, ($urandom % 16) == 0, ($urandom % 16) == 0);
      check_active("R3 R5 R12 random active");
      read_check(16'(16'h0600 + ($urandom % 24)), "R1 R2 R7 R9 R11 random read");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule